// File: doc/BRIEF.md
# LCD Panel Power-State Command Sequencer

This block steps a display driver controller between three power states: deep standby, sleep and normal. A power request names a target state. The block then sends the fixed command script for each edge it must cross, one command at a time, over a valid/ready command port. Each command carries an opcode byte, a payload kind and up to sixteen bits of payload. A transport outside the block serialises each command and answers with a done strobe and an error flag.

A request that spans two hops always passes through sleep. The wake script sends three dummy commands, each followed by a one-millisecond pause timed by a cycle counter. The leg from sleep to normal ends by playing out a 36-entry controller setup table held in an internal ROM. Separate display-on and display-off requests each send a single command and leave the power state unchanged. The recorded power state only moves once a whole request has finished with no transport error.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, `state_o` is 0 (deep standby), `busy_o` is low, `cmd_valid_o` is low and `req_ready_o` is high. The state encoding is 0 = deep standby, 1 = sleep, 2 = normal.
- R2: Deep standby to sleep sends opcode 0x00 with no payload three times, then opcode 0xB0 with byte 0x17. The next command is not presented until at least CLK_FREQ_HZ/1000 cycles after the done strobe of each 0x00 command.
- R3: Sleep to normal sends 0xBC/0x80, 0x3B/0x00, 0xB0/0x16, 0xB8 with word 0xFFF9, and 0x11 with no payload. It then sends the 36-entry setup table, which starts with 0xBA/0x01, ends with 0xD5/0x0E, and includes word writes 0xC3/0x2040, 0xC7/0x5533, 0xEC/0x01F0 and 0xD4/0x11A4. That is 41 commands in all.
- R4: Normal to sleep sends 0x28 with no payload, then 0xB8 with word 0x8002, then 0x10 with no payload.
- R5: Sleep to deep standby sends 0xB0 with byte 0x00.
- R6: Deep standby to normal sends the R2 script followed by the R3 script (45 commands). Normal to deep standby sends the R4 script followed by the R5 script (4 commands). `state_o` changes once, at completion.
- R7: A request for the current state raises `req_done_o` with `req_err_o` low one cycle after it is accepted, and sends no command.
- R8: A target code of 3 completes one cycle after acceptance with `req_err_o` high, sends no command, and leaves `state_o` unchanged.
- R9: A done strobe with `xfer_err_i` high ends the request at once with `req_err_o` high. No further command is sent and `state_o` keeps its old value.
- R10: A display request sends 0x29 with no payload when `disp_on_i` is 1, and 0x28 with no payload when it is 0. In both cases `state_o` is unchanged. A power request takes priority over a display request in the same cycle.
- R11: While `cmd_valid_o` is high and `cmd_ready_i` is low, the opcode, kind and payload hold steady. The kind encoding is 0 = none, 1 = byte (payload in bits 7:0, bits 15:8 zero) and 2 = word.
- R12: From acceptance until completion, `busy_o` is high and `req_ready_o` is low. Any request raised in that window is ignored.
- R13: `req_done_o` is a single-cycle pulse. `state_o` changes only in a cycle where `req_done_o` is high and `req_err_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_req_i | input | 1 | Power-state request strobe |
| pwr_target_i | input | 2 | Requested state (0 standby, 1 sleep, 2 normal) |
| disp_req_i | input | 1 | Display switch request strobe |
| disp_on_i | input | 1 | 1 = display on, 0 = display off |
| req_ready_o | output | 1 | High when a request can be accepted |
| req_done_o | output | 1 | One-cycle completion pulse |
| req_err_o | output | 1 | Error flag, valid with req_done_o |
| cmd_valid_o | output | 1 | Command present |
| cmd_ready_i | input | 1 | Transport accepts the command |
| cmd_code_o | output | 8 | Command opcode |
| cmd_kind_o | output | 2 | Payload kind |
| cmd_data_o | output | 16 | Payload |
| xfer_done_i | input | 1 | Transport finished the accepted command |
| xfer_err_i | input | 1 | Transport error, valid with xfer_done_i |
| state_o | output | 2 | Current power state |
| busy_o | output | 1 | A request is being executed |

## Verification
A request is accepted on a clock edge. Its completion pulse is due at that same edge for same-state and invalid targets, so the bench samples it at the falling edge just after acceptance and expects a latency of exactly one cycle. After a transport done strobe, the next command appears three cycles later, or three plus CLK_FREQ_HZ/1000 cycles later when a pause follows. The bench therefore bounds each wake gap from both sides instead of sampling at a fixed point. The transport model stalls every other command by two cycles, which exercises the hold rule. Every command is logged at the falling edge where it is accepted, and each script is compared entry by entry once the completion pulse is seen.

// File: rtl/lcd_pwr_pkg.sv
package lcd_pwr_pkg;

  typedef enum logic [1:0] {
    PS_STANDBY = 2'd0,
    PS_SLEEP   = 2'd1,
    PS_NORMAL  = 2'd2
  } pwr_state_e;

  typedef enum logic [1:0] {
    OP_CMD  = 2'd0,
    OP_WAIT = 2'd1,
    OP_END  = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    PL_NONE = 2'd0,
    PL_BYTE = 2'd1,
    PL_WORD = 2'd2
  } pl_e;

  typedef enum logic [2:0] {
    F_IDLE, F_RUN, F_ISSUE, F_RESP, F_DELAY
  } fsm_e;

  typedef struct packed {
    op_e         op;
    logic [7:0]  code;
    pl_e         kind;
    logic [15:0] data;
  } step_t;

  localparam int ROM_DEPTH = 60;
  localparam int IDX_W     = $clog2(ROM_DEPTH);

  // script entry points in the step ROM
  localparam int SEG_WAKE     = 0;
  localparam int SEG_UP       = 8;
  localparam int SEG_DOWN     = 50;
  localparam int SEG_OFF      = 54;
  localparam int SEG_DISP_ON  = 56;
  localparam int SEG_DISP_OFF = 58;

  function automatic step_t s_cmd(input logic [7:0] code, input pl_e kind,
                                  input logic [15:0] data);
    step_t s;
    s.op   = OP_CMD;
    s.code = code;
    s.kind = kind;
    s.data = data;
    return s;
  endfunction

  function automatic step_t s_ctl(input op_e op);
    step_t s;
    s.op   = op;
    s.code = 8'h00;
    s.kind = PL_NONE;
    s.data = 16'h0000;
    return s;
  endfunction

endpackage

// File: rtl/lcd_seq_rom.sv
module lcd_seq_rom
  import lcd_pwr_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output step_t            step_o
);

  always_comb begin
    unique case (idx_i)
      // wake: three dummies with pauses, then leave deep standby
      6'd0:  step_o = s_cmd(8'h00, PL_NONE, 16'h0000);
      6'd1:  step_o = s_ctl(OP_WAIT);
      6'd2:  step_o = s_cmd(8'h00, PL_NONE, 16'h0000);
      6'd3:  step_o = s_ctl(OP_WAIT);
      6'd4:  step_o = s_cmd(8'h00, PL_NONE, 16'h0000);
      6'd5:  step_o = s_ctl(OP_WAIT);
      6'd6:  step_o = s_cmd(8'hB0, PL_BYTE, 16'h0017);
      6'd7:  step_o = s_ctl(OP_END);
      // sleep to normal preamble
      6'd8:  step_o = s_cmd(8'hBC, PL_BYTE, 16'h0080);
      6'd9:  step_o = s_cmd(8'h3B, PL_BYTE, 16'h0000);
      6'd10: step_o = s_cmd(8'hB0, PL_BYTE, 16'h0016);
      6'd11: step_o = s_cmd(8'hB8, PL_WORD, 16'hFFF9);
      6'd12: step_o = s_cmd(8'h11, PL_NONE, 16'h0000);
      // setup table
      6'd13: step_o = s_cmd(8'hBA, PL_BYTE, 16'h0001);
      6'd14: step_o = s_cmd(8'hBB, PL_BYTE, 16'h0000);
      6'd15: step_o = s_cmd(8'h3A, PL_BYTE, 16'h0060);
      6'd16: step_o = s_cmd(8'hBF, PL_BYTE, 16'h0010);
      6'd17: step_o = s_cmd(8'hB1, PL_BYTE, 16'h0056);
      6'd18: step_o = s_cmd(8'hB2, PL_BYTE, 16'h0033);
      6'd19: step_o = s_cmd(8'hB3, PL_BYTE, 16'h0011);
      6'd20: step_o = s_cmd(8'hB3, PL_BYTE, 16'h0011);
      6'd21: step_o = s_cmd(8'hB4, PL_BYTE, 16'h0002);
      6'd22: step_o = s_cmd(8'hB5, PL_BYTE, 16'h002B);
      6'd23: step_o = s_cmd(8'hB6, PL_BYTE, 16'h0040);
      6'd24: step_o = s_cmd(8'hB7, PL_BYTE, 16'h0003);
      6'd25: step_o = s_cmd(8'hB9, PL_BYTE, 16'h0004);
      6'd26: step_o = s_cmd(8'hBD, PL_BYTE, 16'h0004);
      6'd27: step_o = s_cmd(8'hBE, PL_BYTE, 16'h0000);
      6'd28: step_o = s_cmd(8'hC0, PL_BYTE, 16'h0011);
      6'd29: step_o = s_cmd(8'hC1, PL_BYTE, 16'h0011);
      6'd30: step_o = s_cmd(8'hC2, PL_BYTE, 16'h0011);
      6'd31: step_o = s_cmd(8'hC3, PL_WORD, 16'h2040);
      6'd32: step_o = s_cmd(8'hC4, PL_WORD, 16'h60C0);
      6'd33: step_o = s_cmd(8'hC5, PL_WORD, 16'h1020);
      6'd34: step_o = s_cmd(8'hC6, PL_WORD, 16'h60C0);
      6'd35: step_o = s_cmd(8'hC7, PL_WORD, 16'h5533);
      6'd36: step_o = s_cmd(8'hC8, PL_BYTE, 16'h0000);
      6'd37: step_o = s_cmd(8'hC9, PL_BYTE, 16'h0000);
      6'd38: step_o = s_cmd(8'hCA, PL_BYTE, 16'h0000);
      6'd39: step_o = s_cmd(8'hCA, PL_BYTE, 16'h0000);
      6'd40: step_o = s_cmd(8'hEC, PL_WORD, 16'h01F0);
      6'd41: step_o = s_cmd(8'hCF, PL_BYTE, 16'h0002);
      6'd42: step_o = s_cmd(8'hD0, PL_WORD, 16'h0804);
      6'd43: step_o = s_cmd(8'hD0, PL_WORD, 16'h0804);
      6'd44: step_o = s_cmd(8'hD1, PL_BYTE, 16'h0001);
      6'd45: step_o = s_cmd(8'hD2, PL_WORD, 16'h0000);
      6'd46: step_o = s_cmd(8'hD3, PL_WORD, 16'h0D0E);
      6'd47: step_o = s_cmd(8'hD4, PL_WORD, 16'h11A4);
      6'd48: step_o = s_cmd(8'hD5, PL_BYTE, 16'h000E);
      6'd49: step_o = s_ctl(OP_END);
      // normal to sleep
      6'd50: step_o = s_cmd(8'h28, PL_NONE, 16'h0000);
      6'd51: step_o = s_cmd(8'hB8, PL_WORD, 16'h8002);
      6'd52: step_o = s_cmd(8'h10, PL_NONE, 16'h0000);
      6'd53: step_o = s_ctl(OP_END);
      // sleep to deep standby
      6'd54: step_o = s_cmd(8'hB0, PL_BYTE, 16'h0000);
      6'd55: step_o = s_ctl(OP_END);
      // display switch
      6'd56: step_o = s_cmd(8'h29, PL_NONE, 16'h0000);
      6'd57: step_o = s_ctl(OP_END);
      6'd58: step_o = s_cmd(8'h28, PL_NONE, 16'h0000);
      default: step_o = s_ctl(OP_END);
    endcase
  end

endmodule

// File: rtl/lcd_wait_timer.sv
module lcd_wait_timer #(
  parameter int unsigned TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);

  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CW'(TICKS - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
  import lcd_pwr_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 100_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pwr_req_i,
  input  logic [1:0]  pwr_target_i,
  input  logic        disp_req_i,
  input  logic        disp_on_i,
  output logic        req_ready_o,
  output logic        req_done_o,
  output logic        req_err_o,
  output logic        cmd_valid_o,
  input  logic        cmd_ready_i,
  output logic [7:0]  cmd_code_o,
  output logic [1:0]  cmd_kind_o,
  output logic [15:0] cmd_data_o,
  input  logic        xfer_done_i,
  input  logic        xfer_err_i,
  output logic [1:0]  state_o,
  output logic        busy_o
);

  localparam int unsigned MS_TICKS = (CLK_FREQ_HZ / 1000 < 1) ? 1 : CLK_FREQ_HZ / 1000;

  fsm_e             fsm_q;
  pwr_state_e       state_q, goal_q;
  logic [IDX_W-1:0] idx_q, chain_idx_q;
  logic             chain_q;
  logic             done_q, err_q;
  step_t            step;
  logic             tmr_start, tmr_expired;

  lcd_seq_rom u_rom (
    .idx_i  (idx_q),
    .step_o (step)
  );

  assign tmr_start = (fsm_q == F_RUN) && (step.op == OP_WAIT);

  lcd_wait_timer #(.TICKS(MS_TICKS)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (tmr_start),
    .expired_o (tmr_expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q       <= F_IDLE;
      state_q     <= PS_STANDBY;
      goal_q      <= PS_STANDBY;
      idx_q       <= '0;
      chain_idx_q <= '0;
      chain_q     <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (fsm_q)
        F_IDLE: begin
          if (pwr_req_i) begin
            if (pwr_target_i == 2'd3) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end else if (pwr_target_i == state_q) begin
              done_q <= 1'b1;
            end else begin
              goal_q  <= pwr_state_e'(pwr_target_i);
              fsm_q   <= F_RUN;
              chain_q <= 1'b0;
              if (state_q == PS_STANDBY) begin
                idx_q       <= IDX_W'(SEG_WAKE);
                chain_q     <= (pwr_target_i == PS_NORMAL);
                chain_idx_q <= IDX_W'(SEG_UP);
              end else if (state_q == PS_NORMAL) begin
                idx_q       <= IDX_W'(SEG_DOWN);
                chain_q     <= (pwr_target_i == PS_STANDBY);
                chain_idx_q <= IDX_W'(SEG_OFF);
              end else begin
                idx_q <= (pwr_target_i == PS_NORMAL) ? IDX_W'(SEG_UP) : IDX_W'(SEG_OFF);
              end
            end
          end else if (disp_req_i) begin
            goal_q  <= state_q;
            chain_q <= 1'b0;
            idx_q   <= disp_on_i ? IDX_W'(SEG_DISP_ON) : IDX_W'(SEG_DISP_OFF);
            fsm_q   <= F_RUN;
          end
        end
        F_RUN: begin
          if (step.op == OP_CMD) begin
            fsm_q <= F_ISSUE;
          end else if (step.op == OP_WAIT) begin
            fsm_q <= F_DELAY;
          end else if (chain_q) begin
            idx_q   <= chain_idx_q;
            chain_q <= 1'b0;
          end else begin
            state_q <= goal_q;
            done_q  <= 1'b1;
            fsm_q   <= F_IDLE;
          end
        end
        F_ISSUE: if (cmd_ready_i) fsm_q <= F_RESP;
        F_RESP: begin
          if (xfer_done_i) begin
            if (xfer_err_i) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
              fsm_q  <= F_IDLE;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
              fsm_q <= F_RUN;
            end
          end
        end
        F_DELAY: begin
          if (tmr_expired) begin
            idx_q <= idx_q + IDX_W'(1);
            fsm_q <= F_RUN;
          end
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  assign req_ready_o = (fsm_q == F_IDLE);
  assign busy_o      = (fsm_q != F_IDLE);
  assign req_done_o  = done_q;
  assign req_err_o   = err_q;
  assign state_o     = state_q;
  assign cmd_valid_o = (fsm_q == F_ISSUE);
  assign cmd_code_o  = step.code;
  assign cmd_kind_o  = step.kind;
  assign cmd_data_o  = step.data;

endmodule

// File: rtl/lcd_pwr_seq_chk.sv
module lcd_pwr_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_ready_o,
  input logic        req_done_o,
  input logic        req_err_o,
  input logic        cmd_valid_o,
  input logic        cmd_ready_i,
  input logic [7:0]  cmd_code_o,
  input logic [1:0]  cmd_kind_o,
  input logic [15:0] cmd_data_o,
  input logic [1:0]  state_o,
  input logic        busy_o
);

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_code_o)
      && $stable(cmd_kind_o) && $stable(cmd_data_o));

  a_r11_kind_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_kind_o != 2'd3);

  a_r11_byte_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_kind_o == 2'd1 |-> cmd_data_o[15:8] == 8'h00);

  a_r12_no_ready_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_ready_o);

  a_r12_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o);

  a_r13_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |=> !req_done_o);

  a_r13_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(state_o) |-> req_done_o && !req_err_o);

  a_r1_state_enc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3);

endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk u_chk (.*);

// File: tb/lcd_pwr_seq_tb.sv
module lcd_pwr_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int FREQ       = 20000;
  localparam int WAIT_CYC   = FREQ / 1000;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        pwr_req_i, disp_req_i, disp_on_i;
  logic [1:0]  pwr_target_i;
  logic        req_ready_o, req_done_o, req_err_o;
  logic        cmd_valid_o, cmd_ready_i;
  logic [7:0]  cmd_code_o;
  logic [1:0]  cmd_kind_o;
  logic [15:0] cmd_data_o;
  logic        xfer_done_i, xfer_err_i;
  logic [1:0]  state_o;
  logic        busy_o;

  int vectors = 0, miscompares = 0, cyc = 0;
  logic [25:0] log_e [64];
  int log_vis [64];
  int log_dn [64];
  int log_n = 0, err_at = -1, stall_cnt = 0;
  bit ph = 0;
  logic [25:0] held;
  logic last_err;
  int lat;

  lcd_pwr_seq #(.CLK_FREQ_HZ(FREQ)) u_dut (.*, .clk_i(clk));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // transport model: every other command stalls two cycles
  always @(negedge clk) begin
    cmd_ready_i <= 1'b0;
    xfer_done_i <= 1'b0;
    xfer_err_i  <= 1'b0;
    if (ph) begin
      xfer_done_i <= 1'b1;
      xfer_err_i  <= (log_n - 1 == err_at);
      log_dn[log_n-1] = cyc;
      ph = 0;
    end else if (cmd_valid_o && log_n < 64) begin
      if (stall_cnt == 0) begin
        held = {cmd_code_o, cmd_kind_o, cmd_data_o};
        log_vis[log_n] = cyc;
      end else begin
        chk({cmd_code_o, cmd_kind_o, cmd_data_o} == held, "R11 hold",
            32'({cmd_code_o, cmd_kind_o, cmd_data_o}), 32'(held));
      end
      if (stall_cnt >= ((log_n % 2 == 1) ? 2 : 0)) begin
        cmd_ready_i <= 1'b1;
        log_e[log_n] = held;
        log_n++;
        stall_cnt = 0;
        ph = 1;
      end else begin
        stall_cnt++;
      end
    end
  end

  function automatic logic [25:0] e(input logic [7:0] c, input logic [1:0] k, input logic [15:0] d);
    return {c, k, d};
  endfunction

  function automatic logic [25:0] exp_wake(input int i);
    return (i < 3) ? e(8'h00, 2'd0, 16'h0) : e(8'hB0, 2'd1, 16'h0017);
  endfunction

  function automatic logic [25:0] exp_up(input int i);
    case (i)
      0: return e(8'hBC,1,16'h80);   1: return e(8'h3B,1,16'h00);
      2: return e(8'hB0,1,16'h16);   3: return e(8'hB8,2,16'hFFF9);
      4: return e(8'h11,0,16'h00);   5: return e(8'hBA,1,16'h01);
      6: return e(8'hBB,1,16'h00);   7: return e(8'h3A,1,16'h60);
      8: return e(8'hBF,1,16'h10);   9: return e(8'hB1,1,16'h56);
      10: return e(8'hB2,1,16'h33);  11: return e(8'hB3,1,16'h11);
      12: return e(8'hB3,1,16'h11);  13: return e(8'hB4,1,16'h02);
      14: return e(8'hB5,1,16'h2B);  15: return e(8'hB6,1,16'h40);
      16: return e(8'hB7,1,16'h03);  17: return e(8'hB9,1,16'h04);
      18: return e(8'hBD,1,16'h04);  19: return e(8'hBE,1,16'h00);
      20: return e(8'hC0,1,16'h11);  21: return e(8'hC1,1,16'h11);
      22: return e(8'hC2,1,16'h11);  23: return e(8'hC3,2,16'h2040);
      24: return e(8'hC4,2,16'h60C0); 25: return e(8'hC5,2,16'h1020);
      26: return e(8'hC6,2,16'h60C0); 27: return e(8'hC7,2,16'h5533);
      28: return e(8'hC8,1,16'h00);  29: return e(8'hC9,1,16'h00);
      30: return e(8'hCA,1,16'h00);  31: return e(8'hCA,1,16'h00);
      32: return e(8'hEC,2,16'h01F0); 33: return e(8'hCF,1,16'h02);
      34: return e(8'hD0,2,16'h0804); 35: return e(8'hD0,2,16'h0804);
      36: return e(8'hD1,1,16'h01);  37: return e(8'hD2,2,16'h0000);
      38: return e(8'hD3,2,16'h0D0E); 39: return e(8'hD4,2,16'h11A4);
      default: return e(8'hD5,1,16'h0E);
    endcase
  endfunction

  function automatic logic [25:0] exp_down(input int i);
    case (i)
      0: return e(8'h28,0,16'h0);
      1: return e(8'hB8,2,16'h8002);
      default: return e(8'h10,0,16'h0);
    endcase
  endfunction

  task automatic do_req(input bit disp, input logic [1:0] tgt, input bit on, input bit poke);
    int start;
    @(negedge clk);
    log_n = 0;
    chk(req_ready_o, "R12 ready when idle", 32'(req_ready_o), 1);
    if (disp) begin disp_req_i = 1; disp_on_i = on; end
    else begin pwr_req_i = 1; pwr_target_i = tgt; end
    start = cyc;
    @(negedge clk);
    pwr_req_i = 0; disp_req_i = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy_o && !req_ready_o, "R12 busy window", 32'({busy_o, req_ready_o}), 32'b10);
      pwr_req_i = 1; pwr_target_i = 2'd0;
      @(negedge clk);
      pwr_req_i = 0;
    end
    while (!req_done_o) @(negedge clk);
    lat = cyc - start;
    last_err = req_err_o;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL R12 watchdog act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_ni = 0; pwr_req_i = 0; pwr_target_i = 0; disp_req_i = 0; disp_on_i = 0;
    repeat (3) @(negedge clk);
    chk(state_o == 0 && !busy_o && !cmd_valid_o && req_ready_o, "R1 reset",
        32'({state_o, busy_o, cmd_valid_o, req_ready_o}), 32'b0001);
    rst_ni = 1;

    // R2 standby -> sleep
    do_req(0, 2'd1, 0, 0);
    chk(log_n == 4 && !last_err, "R2 count", log_n, 4);
    for (int i = 0; i < 4; i++) chk(log_e[i] == exp_wake(i), "R2 cmd", log_e[i], exp_wake(i));
    for (int i = 0; i < 3; i++) begin
      chk(log_vis[i+1] - log_dn[i] >= WAIT_CYC && log_vis[i+1] - log_dn[i] <= WAIT_CYC + 4,
          "R2 gap", log_vis[i+1] - log_dn[i], WAIT_CYC + 3);
    end
    chk(state_o == 1, "R2 state", state_o, 1);

    // R7 same state
    do_req(0, 2'd1, 0, 0);
    chk(lat == 1 && !last_err && log_n == 0, "R7 same state", lat, 1);

    // R8 illegal target
    do_req(0, 2'd3, 0, 0);
    chk(lat == 1 && last_err && log_n == 0 && state_o == 1, "R8 bad target",
        32'({last_err, state_o}), 32'b101);

    // R3 sleep -> normal
    do_req(0, 2'd2, 0, 0);
    chk(log_n == 41 && !last_err, "R3 count", log_n, 41);
    for (int i = 0; i < 41; i++) chk(log_e[i] == exp_up(i), "R3 cmd", log_e[i], exp_up(i));
    chk(state_o == 2, "R3 state", state_o, 2);

    // R10 display switch
    do_req(1, 2'd0, 1, 0);
    chk(log_n == 1 && log_e[0] == e(8'h29,0,0) && state_o == 2, "R10 on", log_e[0], e(8'h29,0,0));
    do_req(1, 2'd0, 0, 0);
    chk(log_n == 1 && log_e[0] == e(8'h28,0,0) && state_o == 2, "R10 off", log_e[0], e(8'h28,0,0));

    // R4 normal -> sleep with an ignored request mid-run (R12)
    do_req(0, 2'd1, 0, 1);
    chk(log_n == 3, "R4 count", log_n, 3);
    for (int i = 0; i < 3; i++) chk(log_e[i] == exp_down(i), "R4 cmd", log_e[i], exp_down(i));
    chk(state_o == 1, "R12 ignored request", state_o, 1);

    // R5 sleep -> standby
    do_req(0, 2'd0, 0, 0);
    chk(log_n == 1 && log_e[0] == e(8'hB0,1,16'h0), "R5 cmd", log_e[0], e(8'hB0,1,16'h0));
    chk(state_o == 0, "R5 state", state_o, 0);

    // R6 two hops each way
    do_req(0, 2'd2, 0, 0);
    chk(log_n == 45 && state_o == 2, "R6 up count", log_n, 45);
    for (int i = 0; i < 45; i++) begin
      chk(log_e[i] == ((i < 4) ? exp_wake(i) : exp_up(i - 4)), "R6 up cmd", log_e[i],
          (i < 4) ? exp_wake(i) : exp_up(i - 4));
    end
    do_req(0, 2'd0, 0, 0);
    chk(log_n == 4 && state_o == 0, "R6 down count", log_n, 4);
    for (int i = 0; i < 3; i++) chk(log_e[i] == exp_down(i), "R6 down cmd", log_e[i], exp_down(i));
    chk(log_e[3] == e(8'hB0,1,16'h0), "R6 down last", log_e[3], e(8'hB0,1,16'h0));

    // R9 transport errors
    err_at = 1;
    do_req(0, 2'd1, 0, 0);
    chk(last_err && log_n == 2 && state_o == 0, "R9 abort wake", log_n, 2);
    err_at = 6;
    do_req(0, 2'd2, 0, 0);
    chk(last_err && log_n == 7 && state_o == 0, "R9 abort chained", log_n, 7);
    err_at = -1;
    do_req(0, 2'd1, 0, 0);
    chk(!last_err && state_o == 1, "R9 recover", state_o, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule